// File: doc/BRIEF.md
# Pipelined Converter Sub-Code Combiner

A multi-stage pipelined converter core resolves its input in ten steps. The first stage gives a 4-bit coarse decision. Eight middle stages follow, and each gives a redundant code of 0, 1 or 2. A 3-bit flash ends the chain. The stages work one sample clock apart, so the codes that belong to one sample reach this block over ten successive sample-enable cycles. The block holds each early code in a delay line of its own length until the flash code for the same sample arrives.

Once the codes are aligned, the block adds them with weights that overlap by one bit. A wrong decision in any stage is therefore absorbed by the stage after it. The middle codes count as -1, 0 and +1 around their midpoint. The two least significant bits of the sum are dropped, and the result is clamped into a 12-bit word. The output register moves only on enabled cycles. A one-cycle valid strobe marks each new word once the pipeline has filled after reset.

Top module: `subcode_combiner`

## Requirements
- R1: While reset is high, and after it until the first valid strobe, `out_word` is 0 and `out_vld` is 0.
- R2: `stage_codes` packs the first-stage code in bits [3:0], middle stage j (1..8) in bits [4+2(j-1) +: 2], and the flash code in bits [22:20].
- R3: The word for sample m combines the first-stage code presented at enabled cycle m, middle stage j's code presented at enabled cycle m+j, and the flash code presented at enabled cycle m+9.
- R4: The signed sum is S = c0*1024 + sum over j of cj*2^(10-j) + cf - 1020, and the word is S shifted right by two.
- R5: A sum whose shifted value exceeds 4095 produces 4095.
- R6: A negative sum produces 0.
- R7: The first `out_vld` pulse follows the tenth enabled cycle after reset. After that, every enabled cycle gives a one-cycle `out_vld` pulse and a new word on the next clock.
- R8: While `smp_en` is low, the codes are ignored, no stage advances, `out_word` holds its value and `out_vld` is 0.
- R9: On an enabled cycle, no middle-stage code equals 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample enable; advances every stage |
| stage_codes | input | 23 | Packed stage codes (layout in R2) |
| out_word | output | 12 | Corrected, clamped output word |
| out_vld | output | 1 | One-cycle strobe for a new word |

## Verification
The hardest cases to reach are the two clamp limits. They need one sample whose ten codes are all at their maximum, or that sits just at the zero boundary, and those codes are spread across ten enabled cycles. The bench fixes a code table per sample index and drives each stage skewed by its own index. Certain sample indices carry all-maximum, all-zero and near-zero code sets. Enable gaps are placed among the samples, and scrambled codes are driven during those gaps, so alignment has to survive stalls.

// File: rtl/subcode_combiner.sv
module subcode_combiner #(
  parameter int W0   = 4,
  parameter int NMID = 8,
  parameter int WF   = 3,
  parameter int OUTW = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          smp_en,
  input  logic [W0+2*NMID+WF-1:0]       stage_codes,
  output logic [OUTW-1:0]               out_word,
  output logic                          out_vld
);
  localparam int NSTG = NMID + 2;
  localparam int FLO  = W0 + 2*NMID;
  localparam int SW   = W0 + NMID + WF + 1;
  localparam int DROP = (W0 - 1 + NMID + WF) - OUTW;
  localparam int S0SH = WF - 1 + NMID;
  localparam int OFFS = (1 << S0SH) - (1 << (WF - 1));
  localparam int CNTW = $clog2(NSTG);
  localparam logic [SW-1:0] MAXV = SW'((1 << OUTW) - 1);

  logic [W0-1:0]   tail [NSTG-1];
  logic [CNTW-1:0] cnt;
  logic            filled;

  for (genvar k = 0; k < NSTG-1; k++) begin : g_dly
    localparam int D = NSTG - 1 - k;
    logic [W0-1:0] sr [D];
    logic [W0-1:0] din;
    if (k == 0) begin : g_first
      assign din = stage_codes[W0-1:0];
    end else begin : g_mid
      assign din = W0'(stage_codes[W0+2*(k-1) +: 2]);
      p_legal_code_r9: assert property (@(posedge clk) disable iff (rst)
        smp_en |-> stage_codes[W0+2*(k-1) +: 2] != 2'b11);
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < D; i++) sr[i] <= '0;
      end else if (smp_en) begin
        sr[0] <= din;
        for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
      end
    end
    assign tail[k] = sr[D-1];
  end

  logic [SW-1:0]        acc;
  logic signed [SW-1:0] sv;
  logic [SW-1:0]        q;
  logic [OUTW-1:0]      nxt;

  always_comb begin
    acc = SW'(stage_codes[FLO +: WF]) + (SW'(tail[0]) << S0SH);
    for (int k = 1; k < NSTG-1; k++) acc = acc + (SW'(tail[k]) << (WF - 1 + NMID - k));
    sv = $signed(acc) - SW'(OFFS);
    q  = SW'(sv) >> DROP;
    if (sv < 0)         nxt = '0;
    else if (q > MAXV)  nxt = MAXV[OUTW-1:0];
    else                nxt = q[OUTW-1:0];
  end

  assign filled = (cnt == CNTW'(NSTG - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      out_word <= '0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= smp_en && filled;
      if (smp_en && !filled) cnt <= cnt + 1'b1;
      if (smp_en && filled) out_word <= nxt;
    end
  end

  p_vld_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(smp_en));
  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_word) |-> out_vld);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && out_word == '0));
  p_no_vld_unfilled_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_vld) |-> $past(filled));
endmodule

// File: tb/subcode_combiner_bench.sv
module subcode_combiner_bench;
  localparam int PER = 10;
  localparam int NSAMP = 620;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_en = 1'b0;
  logic [22:0] stage_codes = '0;
  logic [11:0] out_word;
  logic        out_vld;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  subcode_combiner u_subcode_combiner (
    .clk(clk), .rst(rst), .smp_en(smp_en), .stage_codes(stage_codes),
    .out_word(out_word), .out_vld(out_vld)
  );

  always #(PER/2) clk = ~clk;

  function automatic int cd(int m, int k);
    if (m < 0) return 0;
    if (m == 5 || m == 200) return (k == 0) ? 15 : (k == 9) ? 7 : 2;
    if (m == 0 || m == 100) return 0;
    if (m == 300 || m == 301) return (k == 0) ? 0 : (k == 9) ? 3 + (m - 300) : 1;
    if (m == 302) return (k == 0) ? 0 : (k == 9) ? 2 : (k == 8) ? 0 : 1;
    if (k == 0) return m % 16;
    if (k == 9) return (m / 16) % 8;
    return ((m / k) + m * k + (m >> 3)) % 3;
  endfunction

  function automatic int expw(int m);
    int s;
    s = cd(m, 0) * 1024 + cd(m, 9) - 1020;
    for (int j = 1; j <= 8; j++) s += cd(m, j) * (1 << (10 - j));
    if (s < 0) return 0;
    if ((s >> 2) > 4095) return 4095;
    return s >> 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  initial begin
    #(PER*200000);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n = 0;
    int last = 0;
    bit pen = 1'b0;
    int pn = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(out_word == 0, "R1 word", out_word, 0);
      chk(out_vld == 0, "R1 vld", out_vld, 0);
    end
    rst = 1'b0;
    for (int c = 0; n < NSAMP + 10; c++) begin
      @(negedge clk);
      if (pen && pn >= 9) begin
        chk(out_vld == 1, "R7 vld", out_vld, 1);
        last = expw(pn - 9);
        // R3 R4 R5 R6: alignment, weighting and clamping
        chk(out_word == last, "R4 word", out_word, last);
      end else begin
        chk(out_vld == 0, "R7/R8 vld low", out_vld, 0);
        chk(out_word == last, "R8 hold", out_word, last);
      end
      pen = ((c % 5) != 3);
      pn = n;
      smp_en = pen;
      if (pen) begin
        // R2: packed layout, stage k fed sample n-k (skew per R3)
        stage_codes[3:0] = 4'(cd(n, 0));
        for (int j = 1; j <= 8; j++) stage_codes[4+2*(j-1) +: 2] = 2'(cd(n - j, j));
        stage_codes[22:20] = 3'(cd(n - 9, 9));
        n++;
      end else begin
        stage_codes = 23'(c * 40503 + 12345);
      end
    end
    @(negedge clk);
    smp_en = 1'b0;
    @(negedge clk);
    chk(out_vld == 0, "R8 idle", out_vld, 0);
    chk(expw(5) == 4095, "R5 table", expw(5), 4095);
    chk(expw(0) == 0, "R6 table", expw(0), 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule